// File: doc/BRIEF.md
# Sector Request Coalescing Scheduler

This block sits between a stream of storage read/write requests and a transfer engine that moves whole sectors. Each request carries an owner tag, a direction, a byte position on the device, a byte length and a memory address. The scheduler rejects requests that are not sector aligned and completes requests that fall wholly past the device end without moving data. It shortens requests that run over the end. Requests on consecutive sectors with the same direction are gathered into one job. The job is held as a small table of transfer slots, each slot naming its owner, start sector, byte count, user address and staging-buffer offset.

A job is issued to the transfer engine when a request cannot be chained, when the staging buffer or the slot table fills, or when a flush is requested. In buffered mode the whole job moves as one transfer. If that transfer fails, the remaining slots are retried one at a time. A bad-sector error, or a run of consecutive errors reaching the limit, fails the owning request and drops the job. Every successful transfer is reported slot by slot, so that each owner can reduce its outstanding byte count.

Top module: `sched_coalescer`

## Requirements
- R1: A request whose position or length has any of the low log2(SECT_BYTES) bits set produces a result with res_code 1 (invalid) and adds no slot.
- R2: A request with position at or beyond DEV_SECTORS*SECT_BYTES, or with length zero, produces a result with res_code 0 and starts no transfer.
- R3: A request that overruns the device end is shortened to end exactly at the device end, and its result carries res_code 0.
- R4: If a job is pending and a new request's first sector differs from the expected next sector (previous start sector plus its length in sectors), or its direction differs from the job's, the pending job is issued before the request is added.
- R5: In buffered mode a job holds at most BUF_SECT sectors. A request that does not fit is split: the part that fits completes the current job, the job is issued, and the rest starts a new job.
- R6: A job is issued when all NSLOT slots are occupied and another piece must be added.
- R7: In buffered mode a job's first transfer starts at the first slot's sector, covers the sum of its slots' sectors, and carries the first slot's staging offset (bytes queued ahead of it in the job). The direction is the one latched by the job's first slot.
- R8: After a failed transfer, the remaining slots are retried one slot per transfer. A bad-sector error, or the MAX_ERR-th consecutive error, raises fail_valid with the owner of the oldest unfinished slot, and the job is dropped.
- R9: After each successful transfer the error count clears, and one done_valid pulse per covered slot reports that slot's owner and byte count, in slot order.
- R10: A flush with no pending job raises flush_done on the next cycle. A flush of a pending job raises flush_done once the job has finished or failed.
- R11: xfer_start is a single-cycle pulse, and no new start is raised while a transfer awaits xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Scheduler can take a request or flush this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Owner tag of the request |
| req_pos | input | POS_W | Byte position on the device |
| req_len | input | LEN_W | Byte length |
| req_addr | input | ADDR_W | Memory address of the data |
| flush_valid | input | 1 | Issue the pending job (taken when req_ready and no request) |
| res_valid | output | 1 | Scheduling result for one request |
| res_id | output | ID_W | Owner tag of that result |
| res_code | output | 1 | 0 = accepted or nothing to do, 1 = invalid argument |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_write | output | 1 | Direction of the transfer |
| xfer_sector | output | POS_W-log2(SECT_BYTES) | First sector |
| xfer_nsec | output | LEN_W+log2(NSLOT+1)-log2(SECT_BYTES) | Sector count |
| xfer_dma | output | ADDR_W | Staging offset (buffered) or user address |
| xfer_user | output | ADDR_W | User address of the first slot |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | With xfer_done: transfer failed |
| xfer_bad | input | 1 | With xfer_err: failure was a bad sector |
| done_valid | output | 1 | One slot completed |
| done_id | output | ID_W | Owner of the completed slot |
| done_bytes | output | LEN_W | Bytes completed for that owner |
| fail_valid | output | 1 | Owner failed with an I/O error |
| fail_id | output | ID_W | Owner that failed |
| flush_done | output | 1 | Flush finished |

## Verification
Every cycle, the assertions check the single-cycle start pulse, the job-size and slot-count bounds, that a failure only follows an erroring transfer, and that completed byte counts are whole nonzero sectors. They also check that an invalid request leaves the slot count untouched and that an empty flush answers at once. Only the scenarios show the coalescing decisions themselves: chaining across consecutive sectors, breaking on a gap or a direction change, splitting at the buffer limit, issuing on a full slot table, clipping at the device end, and the order of per-slot retries and failures after engine errors.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_ADD, ST_ISSUE, ST_WAIT, ST_RETIRE
  } sched_st_e;

  localparam logic RES_OK    = 1'b0;
  localparam logic RES_INVAL = 1'b1;
endpackage

// File: rtl/sched_req_check.sv
module sched_req_check #(
  parameter int POS_W       = 32,
  parameter int LEN_W       = 16,
  parameter int SECT_BYTES  = 512,
  parameter int DEV_SECTORS = 4096,
  localparam int SHIFT = $clog2(SECT_BYTES),
  localparam int BLK_W = POS_W - SHIFT
) (
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  output logic             bad_align,
  output logic             no_xfer,
  output logic [LEN_W-1:0] len_clip,
  output logic [BLK_W-1:0] start_blk
);
  localparam logic [63:0]    DEV_L     = 64'(DEV_SECTORS) * 64'(SECT_BYTES);
  localparam logic [POS_W:0] DEV_BYTES = DEV_L[POS_W:0];

  logic [POS_W:0] end_b;
  logic [POS_W:0] tail;

  always_comb begin
    bad_align = (|pos[SHIFT-1:0]) | (|len[SHIFT-1:0]);
    no_xfer   = ({1'b0, pos} >= DEV_BYTES) || (len == '0);
    end_b     = {1'b0, pos} + (POS_W+1)'(len);
    tail      = DEV_BYTES - {1'b0, pos};
    len_clip  = (end_b > DEV_BYTES) ? tail[LEN_W-1:0] : len;
    start_blk = pos[POS_W-1:SHIFT];
  end
endmodule

// File: rtl/sched_slot_table.sv
module sched_slot_table #(
  parameter int NSLOT  = 8,
  parameter int ID_W   = 4,
  parameter int BLK_W  = 23,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 24,
  localparam int IDX_W = $clog2(NSLOT),
  localparam int SL_W  = ID_W + BLK_W + LEN_W + 2*ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [LEN_W-1:0]  wr_bytes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_dma,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ID_W-1:0]   rd_id,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [LEN_W-1:0]  rd_bytes,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] rd_dma
);
  logic [SL_W-1:0] slot_a [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SL_W-1:0] slot_r;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(s))) begin
        slot_r <= {wr_id, wr_blk, wr_bytes, wr_addr, wr_dma};
      end
    end
    assign slot_a[s] = slot_r;
  end

  assign {rd_id, rd_blk, rd_bytes, rd_addr, rd_dma} = slot_a[rd_idx];
endmodule

// File: rtl/sched_coalescer.sv
module sched_coalescer
  import sched_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int LEN_W       = 16,
  parameter int ADDR_W      = 24,
  parameter int ID_W        = 4,
  parameter int SECT_BYTES  = 512,
  parameter int DEV_SECTORS = 4096,
  parameter int NSLOT       = 8,
  parameter int BUF_SECT    = 16,
  parameter int MAX_ERR     = 4,
  parameter bit BUFFERED    = 1'b1,
  localparam int SHIFT     = $clog2(SECT_BYTES),
  localparam int BLK_W     = POS_W - SHIFT,
  localparam int CNT_W     = $clog2(NSLOT + 1),
  localparam int IDX_W     = $clog2(NSLOT),
  localparam int JB_W      = LEN_W + CNT_W,
  localparam int NSEC_W    = JB_W - SHIFT,
  localparam int ERR_W     = $clog2(MAX_ERR + 1),
  localparam int BUF_BYTES = BUF_SECT * SECT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ID_W-1:0]   req_id,
  input  logic [POS_W-1:0]  req_pos,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flush_valid,
  output logic              res_valid,
  output logic [ID_W-1:0]   res_id,
  output logic              res_code,
  output logic              xfer_start,
  output logic              xfer_write,
  output logic [BLK_W-1:0]  xfer_sector,
  output logic [NSEC_W-1:0] xfer_nsec,
  output logic [ADDR_W-1:0] xfer_dma,
  output logic [ADDR_W-1:0] xfer_user,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic              xfer_bad,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [LEN_W-1:0]  done_bytes,
  output logic              fail_valid,
  output logic [ID_W-1:0]   fail_id,
  output logic              flush_done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sched_st_e st_q, st_d;
  logic [ID_W-1:0]   cur_id_q, cur_id_d;
  logic              cur_w_q, cur_w_d;
  logic [POS_W-1:0]  cur_pos_q, cur_pos_d;
  logic [LEN_W-1:0]  cur_len_q, cur_len_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic [BLK_W-1:0]  cur_blk_q, cur_blk_d, next_q, next_d;
  logic [LEN_W-1:0]  cur_left_q, cur_left_d;
  logic [CNT_W-1:0]  nslots_q, nslots_d, head_q, head_d;
  logic [JB_W-1:0]   job_bytes_q, job_bytes_d, left_q, left_d, rt_q, rt_d;
  logic              job_w_q, job_w_d, many_q, many_d, pend_q, pend_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              res_v_d, res_c_d, done_v_d, fail_v_d, flush_d, xs_d, xw_d;
  logic [ID_W-1:0]   res_id_d, done_id_d, fail_id_d;
  logic [LEN_W-1:0]  done_b_d;
  logic [BLK_W-1:0]  xsec_d;
  logic [NSEC_W-1:0] xnsec_d;
  logic [ADDR_W-1:0] xdma_d, xuser_d;

  logic              bad_align, no_xfer;
  logic [LEN_W-1:0]  len_clip;
  logic [BLK_W-1:0]  start_blk;

  sched_req_check #(
    .POS_W(POS_W), .LEN_W(LEN_W), .SECT_BYTES(SECT_BYTES), .DEV_SECTORS(DEV_SECTORS)
  ) u_check (
    .pos(cur_pos_q), .len(cur_len_q), .bad_align(bad_align), .no_xfer(no_xfer),
    .len_clip(len_clip), .start_blk(start_blk)
  );

  logic              wr_en;
  logic [ADDR_W-1:0] wr_dma;
  logic [LEN_W-1:0]  chunk;
  logic [ID_W-1:0]   rd_id;
  logic [BLK_W-1:0]  rd_blk;
  logic [LEN_W-1:0]  rd_bytes;
  logic [ADDR_W-1:0] rd_addr, rd_dma;

  sched_slot_table #(
    .NSLOT(NSLOT), .ID_W(ID_W), .BLK_W(BLK_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_slots (
    .clk(clk), .wr_en(wr_en), .wr_idx(nslots_q[IDX_W-1:0]), .wr_id(cur_id_q),
    .wr_blk(cur_blk_q), .wr_bytes(chunk), .wr_addr(cur_addr_q), .wr_dma(wr_dma),
    .rd_idx(head_q[IDX_W-1:0]), .rd_id(rd_id), .rd_blk(rd_blk), .rd_bytes(rd_bytes),
    .rd_addr(rd_addr), .rd_dma(rd_dma)
  );

  logic [JB_W-1:0] room, xbytes;
  logic            job_full, clear_job, finish;

  always_comb begin
    room     = JB_W'(BUF_BYTES) - job_bytes_q;
    chunk    = (BUFFERED && (JB_W'(cur_left_q) > room)) ? room[LEN_W-1:0] : cur_left_q;
    job_full = (nslots_q == CNT_W'(NSLOT)) ||
               (BUFFERED && (job_bytes_q == JB_W'(BUF_BYTES)));
    wr_dma   = BUFFERED ? ADDR_W'(job_bytes_q) : cur_addr_q;
    xbytes   = many_q ? left_q : JB_W'(rd_bytes);
  end

  always_comb begin
    st_d = st_q;
    cur_id_d = cur_id_q; cur_w_d = cur_w_q; cur_pos_d = cur_pos_q; cur_len_d = cur_len_q;
    cur_addr_d = cur_addr_q; cur_blk_d = cur_blk_q; cur_left_d = cur_left_q; next_d = next_q;
    nslots_d = nslots_q; head_d = head_q; job_bytes_d = job_bytes_q; left_d = left_q;
    rt_d = rt_q; job_w_d = job_w_q; many_d = many_q; pend_d = pend_q; err_d = err_q;
    res_v_d = 1'b0; res_c_d = RES_OK; res_id_d = cur_id_q;
    done_v_d = 1'b0; done_id_d = rd_id; done_b_d = rd_bytes;
    fail_v_d = 1'b0; fail_id_d = rd_id; flush_d = 1'b0;
    xs_d = 1'b0; xw_d = xfer_write; xsec_d = xfer_sector; xnsec_d = xfer_nsec;
    xdma_d = xfer_dma; xuser_d = xfer_user;
    wr_en = 1'b0; clear_job = 1'b0; finish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cur_id_d = req_id; cur_w_d = req_write; cur_pos_d = req_pos;
          cur_len_d = req_len; cur_addr_d = req_addr;
          st_d = ST_EVAL;
        end else if (flush_valid) begin
          if (nslots_q == '0) flush_d = 1'b1;
          else begin pend_d = 1'b0; st_d = ST_ISSUE; end
        end
      end
      ST_EVAL: begin
        if (bad_align) begin
          res_v_d = 1'b1; res_c_d = RES_INVAL; st_d = ST_IDLE;
        end else if (no_xfer) begin
          res_v_d = 1'b1; st_d = ST_IDLE;
        end else begin
          cur_left_d = len_clip;
          cur_blk_d  = start_blk;
          next_d     = start_blk + BLK_W'(len_clip >> SHIFT);
          if ((nslots_q != '0) &&
              ((BUFFERED && (start_blk != next_q)) || (cur_w_q != job_w_q))) begin
            pend_d = 1'b1; st_d = ST_ISSUE;
          end else st_d = ST_ADD;
        end
      end
      ST_ADD: begin
        if (job_full) begin
          pend_d = 1'b1; st_d = ST_ISSUE;
        end else begin
          wr_en = 1'b1;
          if (nslots_q == '0) job_w_d = cur_w_q;
          nslots_d    = nslots_q + 1'b1;
          job_bytes_d = job_bytes_q + JB_W'(chunk);
          left_d      = left_q + JB_W'(chunk);
          cur_blk_d   = cur_blk_q + BLK_W'(chunk >> SHIFT);
          cur_addr_d  = cur_addr_q + ADDR_W'(chunk);
          cur_left_d  = cur_left_q - chunk;
          if (chunk == cur_left_q) begin res_v_d = 1'b1; st_d = ST_IDLE; end
        end
      end
      ST_ISSUE: begin
        xs_d = 1'b1; xw_d = job_w_q; xsec_d = rd_blk;
        xnsec_d = xbytes[JB_W-1:SHIFT]; xdma_d = rd_dma; xuser_d = rd_addr;
        rt_d = xbytes;
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (xfer_done) begin
          if (xfer_err) begin
            if (xfer_bad || (err_q == ERR_W'(MAX_ERR - 1))) begin
              fail_v_d = 1'b1; clear_job = 1'b1; finish = 1'b1;
            end else begin
              err_d = err_q + 1'b1; many_d = 1'b0; st_d = ST_ISSUE;
            end
          end else begin
            err_d = '0; st_d = ST_RETIRE;
          end
        end
      end
      ST_RETIRE: begin
        done_v_d = 1'b1;
        head_d   = head_q + 1'b1;
        left_d   = left_q - JB_W'(rd_bytes);
        rt_d     = rt_q - JB_W'(rd_bytes);
        if (rt_q == JB_W'(rd_bytes)) begin
          if ((head_q + 1'b1) == nslots_q) begin clear_job = 1'b1; finish = 1'b1; end
          else st_d = ST_ISSUE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (clear_job) begin
      nslots_d = '0; head_d = '0; job_bytes_d = '0; left_d = '0;
      err_d = '0; many_d = BUFFERED;
    end
    if (finish) begin
      if (pend_q) begin pend_d = 1'b0; st_d = ST_ADD; end
      else begin flush_d = 1'b1; st_d = ST_IDLE; end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= ST_IDLE;
      cur_id_q <= '0; cur_w_q <= 1'b0; cur_pos_q <= '0; cur_len_q <= '0;
      cur_addr_q <= '0; cur_blk_q <= '0; cur_left_q <= '0; next_q <= '0;
      nslots_q <= '0; head_q <= '0; job_bytes_q <= '0; left_q <= '0; rt_q <= '0;
      job_w_q <= 1'b0; many_q <= BUFFERED; pend_q <= 1'b0; err_q <= '0;
      res_valid <= 1'b0; res_id <= '0; res_code <= RES_OK;
      done_valid <= 1'b0; done_id <= '0; done_bytes <= '0;
      fail_valid <= 1'b0; fail_id <= '0; flush_done <= 1'b0;
      xfer_start <= 1'b0; xfer_write <= 1'b0; xfer_sector <= '0; xfer_nsec <= '0;
      xfer_dma <= '0; xfer_user <= '0;
    end else begin
      st_q <= st_d;
      cur_id_q <= cur_id_d; cur_w_q <= cur_w_d; cur_pos_q <= cur_pos_d; cur_len_q <= cur_len_d;
      cur_addr_q <= cur_addr_d; cur_blk_q <= cur_blk_d; cur_left_q <= cur_left_d; next_q <= next_d;
      nslots_q <= nslots_d; head_q <= head_d; job_bytes_q <= job_bytes_d; left_q <= left_d;
      rt_q <= rt_d; job_w_q <= job_w_d; many_q <= many_d; pend_q <= pend_d; err_q <= err_d;
      res_valid <= res_v_d; res_id <= res_id_d; res_code <= res_c_d;
      done_valid <= done_v_d; done_id <= done_id_d; done_bytes <= done_b_d;
      fail_valid <= fail_v_d; fail_id <= fail_id_d; flush_done <= flush_d;
      xfer_start <= xs_d; xfer_write <= xw_d; xfer_sector <= xsec_d; xfer_nsec <= xnsec_d;
      xfer_dma <= xdma_d; xfer_user <= xuser_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  // ---------------- assertions ----------------
  assert_inval_not_queued_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && (res_code == RES_INVAL)) |-> $stable(nslots_q));

  assert_job_bound_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !BUFFERED || (job_bytes_q <= JB_W'(BUF_BYTES)));

  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nslots_q <= CNT_W'(NSLOT));

  assert_fail_after_err_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fail_valid |-> $past(xfer_done && xfer_err));

  assert_done_whole_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_valid |-> ((done_bytes[SHIFT-1:0] == '0) && (done_bytes != '0)));

  assert_empty_flush_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_ready && !req_valid && flush_valid && (nslots_q == '0)) |=> flush_done);

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_start |=> !xfer_start);

  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == ST_WAIT) && !xfer_done) |=> !xfer_start);
endmodule

// File: tb/sched_coalescer_test.sv
module sched_coalescer_test;
  localparam int SB   = 512;
  localparam int DEVS = 64;
  localparam int DEVB = DEVS * SB;
  localparam int BUFB = 16 * SB;
  localparam int NSL  = 8;
  localparam int MAXE = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, flush_valid;
  logic [3:0] req_id;
  logic [31:0] req_pos;
  logic [15:0] req_len;
  logic [23:0] req_addr;
  logic res_valid, res_code, xfer_start, xfer_write, done_valid, fail_valid, flush_done;
  logic [3:0] res_id, done_id, fail_id;
  logic [22:0] xfer_sector;
  logic [10:0] xfer_nsec;
  logic [23:0] xfer_dma, xfer_user;
  logic [15:0] done_bytes;
  logic xfer_done, xfer_err, xfer_bad;

  sched_coalescer #(.DEV_SECTORS(DEVS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_id(req_id), .req_pos(req_pos), .req_len(req_len),
    .req_addr(req_addr), .flush_valid(flush_valid), .res_valid(res_valid),
    .res_id(res_id), .res_code(res_code), .xfer_start(xfer_start),
    .xfer_write(xfer_write), .xfer_sector(xfer_sector), .xfer_nsec(xfer_nsec),
    .xfer_dma(xfer_dma), .xfer_user(xfer_user), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .xfer_bad(xfer_bad), .done_valid(done_valid),
    .done_id(done_id), .done_bytes(done_bytes), .fail_valid(fail_valid),
    .fail_id(fail_id), .flush_done(flush_done)
  );

  typedef struct { int a; int b; int c; int d; int tag; } ev_t;
  ev_t q_r[$], q_x[$], q_d[$], q_f[$];
  int  n_flush_exp = 0;
  int  n_chk = 0, n_fail = 0;
  int  resp[int];
  bit  ended = 0;

  function automatic void chk(int tag, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0d expected %0d", tag, what, got, exp);
    end
  endfunction

  function automatic void unexpected(int tag, string what);
    n_chk++; n_fail++;
    $display("FAIL R%0d unexpected %s: got event expected none", tag, what);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_id[$], m_blk[$], m_bytes[$], m_dma[$];
  int m_jbytes = 0, m_w = 0, m_next = 0, m_xk = 0;

  function automatic void m_finish();
    int head = 0, many = 1, errs = 0, cnt, r, n;
    n = m_id.size();
    if (n == 0) return;
    while (head < n) begin
      if (many != 0) begin cnt = 0; for (int i = head; i < n; i++) cnt += m_bytes[i]; end
      else cnt = m_bytes[head];
      q_x.push_back('{m_blk[head], cnt / SB, m_dma[head], m_w, 7});
      r = resp.exists(m_xk) ? resp[m_xk] : 0;
      m_xk++;
      if (r != 0) begin
        errs++;
        if (r == 2 || errs == MAXE) begin q_f.push_back('{m_id[head], 0, 0, 0, 8}); break; end
        many = 0;
        continue;
      end
      errs = 0;
      while (cnt > 0) begin
        q_d.push_back('{m_id[head], m_bytes[head], 0, 0, 9});
        cnt -= m_bytes[head];
        head++;
      end
    end
    m_id.delete(); m_blk.delete(); m_bytes.delete(); m_dma.delete();
    m_jbytes = 0;
  endfunction

  function automatic void m_request(int id, int w, int pos, int len);
    int blk, chunk;
    if ((pos % SB) != 0 || (len % SB) != 0) begin q_r.push_back('{id, 1, 0, 0, 1}); return; end
    if (pos >= DEVB || len == 0) begin q_r.push_back('{id, 0, 0, 0, 2}); return; end
    if (pos + len > DEVB) len = DEVB - pos;
    blk = pos / SB;
    if (m_id.size() > 0 && (blk != m_next || w != m_w)) m_finish();
    m_next = blk + len / SB;
    while (len > 0) begin
      if (m_id.size() == NSL || m_jbytes == BUFB) m_finish();
      chunk = (len < BUFB - m_jbytes) ? len : BUFB - m_jbytes;
      if (m_id.size() == 0) m_w = w;
      m_id.push_back(id); m_blk.push_back(blk); m_bytes.push_back(chunk);
      m_dma.push_back(m_jbytes);
      m_jbytes += chunk; blk += chunk / SB; len -= chunk;
    end
    q_r.push_back('{id, 0, 0, 0, 3});
  endfunction

  // ---------------- engine, monitors, watchdog (sampled at negedge) ----------------
  int eng_busy = 0, eng_wait = 0, eng_k = 0, eng_idx = 0, cyc = 0;
  ev_t e;

  always @(negedge clk) begin
    cyc++;
    xfer_done = 1'b0; xfer_err = 1'b0; xfer_bad = 1'b0;
    if (rst_n) begin
      if (eng_busy != 0) begin
        if (eng_wait == 0) begin
          xfer_done = 1'b1;
          if (resp.exists(eng_idx) && resp[eng_idx] != 0) begin
            xfer_err = 1'b1; xfer_bad = (resp[eng_idx] == 2);
          end
          eng_busy = 0;
        end else eng_wait--;
      end
      if (xfer_start) begin
        if (eng_busy != 0) unexpected(11, "start while busy");
        if (q_x.size() == 0) unexpected(2, "transfer start");
        else begin
          e = q_x.pop_front();
          chk(e.tag, int'(xfer_sector), e.a, "xfer sector");
          chk(e.tag, int'(xfer_nsec), e.b, "xfer sector count");
          chk(e.tag, int'(xfer_dma), e.c, "xfer staging offset");
          chk(e.tag, int'(xfer_write), e.d, "xfer direction");
        end
        eng_busy = 1; eng_wait = 2; eng_idx = eng_k; eng_k++;
      end
      if (res_valid) begin
        if (q_r.size() == 0) unexpected(3, "result");
        else begin
          e = q_r.pop_front();
          chk(e.tag, int'(res_id), e.a, "result id");
          chk(e.tag, int'(res_code), e.b, "result code");
        end
      end
      if (done_valid) begin
        if (q_d.size() == 0) unexpected(9, "slot done");
        else begin
          e = q_d.pop_front();
          chk(e.tag, int'(done_id), e.a, "done owner");
          chk(e.tag, int'(done_bytes), e.b, "done bytes");
        end
      end
      if (fail_valid) begin
        if (q_f.size() == 0) unexpected(8, "failure");
        else begin e = q_f.pop_front(); chk(8, int'(fail_id), e.a, "fail owner"); end
      end
      if (flush_done) begin
        if (n_flush_exp == 0) unexpected(10, "flush done");
        else begin n_chk++; n_flush_exp--; end
      end
    end
    if (cyc > 100000 && !ended) begin
      ended = 1; n_chk++; n_fail++;
      $display("FAIL R11 watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(int id, int w, int pos, int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    m_request(id, w, pos, len);
    req_valid = 1'b1; req_id = 4'(id); req_write = w[0];
    req_pos = 32'(pos); req_len = 16'(len); req_addr = 24'(pos + 24'h100000);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    m_finish();
    n_flush_exp++;
    flush_valid = 1'b1;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((q_x.size() + q_d.size() + q_f.size() + q_r.size() + n_flush_exp) != 0 && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; flush_valid = 1'b0; req_write = 1'b0;
    req_id = '0; req_pos = '0; req_len = '0; req_addr = '0;
    xfer_done = 1'b0; xfer_err = 1'b0; xfer_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state: idle, no start pulse (R10, R11)
    chk(10, int'(req_ready), 1, "ready after reset");
    chk(11, int'(xfer_start), 0, "start after reset");

    // R1: misaligned length, misaligned position
    send(1, 0, 512, 100);
    send(2, 0, 3, 512);
    // R2: beyond device end, zero length
    send(3, 0, DEVB, 512);
    send(4, 0, 0, 0);
    // R10: flush with nothing pending
    flush();
    drain();

    // R7: consecutive requests chained into one transfer
    send(5, 0, 0, 1024);
    send(6, 0, 1024, 2048);
    flush();
    drain();

    // R4: gap in sectors, then direction change
    send(7, 0, 8192, 512);
    send(8, 0, 0, 512);
    send(9, 1, 512, 512);
    flush();
    drain();

    // R5: 20-sector request split at the 16-sector buffer
    send(10, 0, 4096, 10240);
    flush();
    drain();

    // R6: nine single-sector requests, slot table holds eight
    for (int i = 0; i < 9; i++) send(i + 1, 1, i * SB, SB);
    flush();
    drain();

    // R3: request clipped at device end
    send(11, 0, DEVB - 1024, 2048);
    flush();
    drain();

    // R8, R9: multi-slot failure, then per-slot retries with one more error
    send(12, 0, 0, 512);
    send(13, 0, 512, 1024);
    send(14, 0, 1536, 512);
    resp[m_xk] = 1; resp[m_xk + 2] = 1;
    flush();
    drain();

    // R8: bad-sector failure
    send(1, 0, 2048, 1024);
    resp[m_xk] = 2;
    flush();
    drain();

    // R8: MAX_ERR consecutive errors
    send(2, 1, 4096, 512);
    for (int i = 0; i < MAXE; i++) resp[m_xk + i] = 1;
    flush();
    drain();

    // leftover expectations count as failures
    chk(9, q_x.size() + q_d.size() + q_f.size() + q_r.size() + n_flush_exp, 0, "pending expected events");
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule